// File: doc/BRIEF.md
# 1-Wire Network-Layer Bus Monitor

This block watches a 1-Wire bus without driving it, one layer above the slot decoder. Its inputs are events that have already been decoded: a reset/presence event that carries the presence flag, and single time-slot bit values marked by a strobe. From these it follows the ROM-command sequence. It reports the command byte and whether the command is recognised, then the device address picked in the address phase, then every data byte of the transport phase that comes after.

When the command is a search, the monitor treats each address bit as a triplet of slots: the device's true bit, the device's complemented bit, and the direction bit the master writes. The master-written bits make up the reported address. The true and complement vectors are reported next to it. A command that is not recognised does not stop the monitor. It keeps grouping bits into bytes and marks them as error data until the next reset. All reports are registered one-cycle pulses.

Top module: `owire_netmon`

## Requirements
- R1: A reset/presence event (`rp_valid`) produces, one cycle later, `pres_valid` for exactly one cycle with `pres_flag` equal to `rp_presence`. It returns the monitor to command collection and drops any partly collected byte, address or triplet. A bit strobe in the same cycle as the event is dropped.
- R2: The first 8 bits after a reset/presence event form the command byte, least significant bit first. `cmd_valid` pulses in the cycle after the eighth bit is strobed, and not earlier.
- R3: `cmd_known` is 1 for exactly the eight codes 0x33, 0x0F, 0x55, 0x69, 0xCC, 0x3C, 0xF0 and 0xEC, and 0 for all others.
- R4: After 0x33, 0x0F, 0x55 or 0x69, the next `ADDR_BITS` bits are collected least significant bit first. `rom_valid` pulses with that value on `rom_addr` in the cycle after the last bit.
- R5: After 0xCC or 0x3C, the bits that follow go directly into transport data bytes.
- R6: After 0xF0 or 0xEC, each address bit index takes three strobes in this order: true bit, complement bit, master direction bit. After `ADDR_BITS` triplets, `rom_valid` pulses. `rom_addr` holds the direction bits, `rom_true` holds the true bits and `rom_comp` holds the complement bits, each with index 0 in bit 0.
- R7: Once an address has been reported, every following group of 8 bits is reported on `data_byte`, least significant bit first, with `data_valid` and `data_err`=0. This repeats until the next reset/presence event.
- R8: After any unrecognised command, every following group of 8 bits is reported with `data_valid` and `data_err`=1 until the next reset/presence event.
- R9: At most one of `pres_valid`, `cmd_valid`, `rom_valid` and `data_valid` is high in any cycle. A cycle that has neither a bit strobe nor a reset/presence event is followed by a cycle with none of them high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rp_valid | input | 1 | Reset/presence event strobe |
| rp_presence | input | 1 | Presence flag of that event |
| bit_valid | input | 1 | Time-slot bit strobe |
| bit_value | input | 1 | Value of the strobed slot |
| pres_valid | output | 1 | Presence report pulse |
| pres_flag | output | 1 | Reported presence flag |
| cmd_valid | output | 1 | Command byte report pulse |
| cmd_byte | output | 8 | Command byte |
| cmd_known | output | 1 | Command is one of the eight recognised codes |
| rom_valid | output | 1 | Address report pulse |
| rom_addr | output | ADDR_BITS | Selected address (direction bits when searching) |
| rom_true | output | ADDR_BITS | True bits of the search triplets |
| rom_comp | output | ADDR_BITS | Complement bits of the search triplets |
| data_valid | output | 1 | Data byte report pulse |
| data_byte | output | 8 | Data byte |
| data_err | output | 1 | Byte follows an unrecognised command |

## Verification
The bench builds the monitor with `ADDR_BITS`=16, which keeps each address phase short. This makes it practical to sweep every one of the 256 command codes, each in its own bus transaction. For every code the bench checks the classification, then drives the phase that code leads to (plain address, skip, search triplets or error bytes) and checks the reports against values it computes itself. Separate sequences cover a reset that arrives partway through a byte, a reset that arrives partway through an address, and a bit that coincides with a reset.

// File: rtl/owm_pkg.sv
package owm_pkg;
   typedef enum logic [2:0] {
      ST_CMD,
      ST_ADDR,
      ST_SEARCH,
      ST_XFER,
      ST_BAD
   } owm_state_e;

   typedef enum logic [1:0] {
      CL_ADDR,
      CL_SKIP,
      CL_SEARCH,
      CL_BAD
   } owm_class_e;

   typedef enum logic [1:0] {
      TR_TRUE,
      TR_COMP,
      TR_DIR
   } owm_trip_e;

   localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/owm_cmd_decode.sv
module owm_cmd_decode
   import owm_pkg::*;
(
   input  logic [7:0] code,
   output owm_class_e cls
);
   always_comb begin
      case (code)
         8'h33, 8'h0F, 8'h55, 8'h69: cls = CL_ADDR;
         8'hCC, 8'h3C:               cls = CL_SKIP;
         8'hF0, 8'hEC:               cls = CL_SEARCH;
         default:                    cls = CL_BAD;
      endcase
   end
endmodule

// File: rtl/owm_lsb_shifter.sv
module owm_lsb_shifter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift,
   input  logic         din,
   output logic [W-1:0] q,
   output logic [W-1:0] nxt
);
   if (W < 2) begin : g_bad_width
      $error("owm_lsb_shifter: W must be at least 2");
   end

   // New bits enter at the top, so the first bit ends in bit 0.
   assign nxt = {din, q[W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (clr)   q <= '0;
      else if (shift) q <= nxt;
   end
endmodule

// File: rtl/owire_netmon.sv
module owire_netmon
   import owm_pkg::*;
#(
   parameter int unsigned ADDR_BITS           = 64,
   parameter bit          KEEP_SEARCH_VECTORS = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rp_valid,
   input  logic                 rp_presence,
   input  logic                 bit_valid,
   input  logic                 bit_value,
   output logic                 pres_valid,
   output logic                 pres_flag,
   output logic                 cmd_valid,
   output logic [7:0]           cmd_byte,
   output logic                 cmd_known,
   output logic                 rom_valid,
   output logic [ADDR_BITS-1:0] rom_addr,
   output logic [ADDR_BITS-1:0] rom_true,
   output logic [ADDR_BITS-1:0] rom_comp,
   output logic                 data_valid,
   output logic [7:0]           data_byte,
   output logic                 data_err
);
   localparam int unsigned CW = $clog2(ADDR_BITS);
   localparam logic [CW-1:0] BYTE_LAST = CW'(BYTE_BITS - 1);
   localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_BITS - 1);

   if (ADDR_BITS < BYTE_BITS || (ADDR_BITS % BYTE_BITS) != 0) begin : g_bad_addr
      $error("owire_netmon: ADDR_BITS must be a non-zero multiple of 8");
   end

   owm_state_e st;
   owm_trip_e  trip;
   logic [CW-1:0] cnt;

   logic take;
   assign take = bit_valid && !rp_valid;

   logic in_byte_state;
   assign in_byte_state = (st == ST_CMD) || (st == ST_XFER) || (st == ST_BAD);

   logic [BYTE_BITS-1:0] byte_q, byte_nxt;
   owm_lsb_shifter #(.W(BYTE_BITS)) i_byte_sh (
      .clk(clk), .rst_n(rst_n), .clr(rp_valid),
      .shift(take && in_byte_state), .din(bit_value),
      .q(byte_q), .nxt(byte_nxt)
   );

   logic addr_shift;
   assign addr_shift = take && ((st == ST_ADDR) || (st == ST_SEARCH && trip == TR_DIR));

   logic [ADDR_BITS-1:0] addr_q, addr_nxt;
   owm_lsb_shifter #(.W(ADDR_BITS)) i_addr_sh (
      .clk(clk), .rst_n(rst_n), .clr(rp_valid),
      .shift(addr_shift), .din(bit_value),
      .q(addr_q), .nxt(addr_nxt)
   );

   logic [ADDR_BITS-1:0] true_q, comp_q;
   if (KEEP_SEARCH_VECTORS) begin : g_keep_vec
      logic [ADDR_BITS-1:0] true_nxt, comp_nxt;
      owm_lsb_shifter #(.W(ADDR_BITS)) i_true_sh (
         .clk(clk), .rst_n(rst_n), .clr(rp_valid),
         .shift(take && st == ST_SEARCH && trip == TR_TRUE), .din(bit_value),
         .q(true_q), .nxt(true_nxt)
      );
      owm_lsb_shifter #(.W(ADDR_BITS)) i_comp_sh (
         .clk(clk), .rst_n(rst_n), .clr(rp_valid),
         .shift(take && st == ST_SEARCH && trip == TR_COMP), .din(bit_value),
         .q(comp_q), .nxt(comp_nxt)
      );
   end else begin : g_drop_vec
      assign true_q = '0;
      assign comp_q = '0;
   end

   owm_class_e cls;
   owm_cmd_decode i_dec (.code(byte_nxt), .cls(cls));

   logic byte_done, addr_done;
   assign byte_done = (cnt == BYTE_LAST);
   assign addr_done = (cnt == ADDR_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_CMD;
         trip       <= TR_TRUE;
         cnt        <= '0;
         pres_valid <= 1'b0;
         pres_flag  <= 1'b0;
         cmd_valid  <= 1'b0;
         cmd_byte   <= '0;
         cmd_known  <= 1'b0;
         rom_valid  <= 1'b0;
         rom_addr   <= '0;
         rom_true   <= '0;
         rom_comp   <= '0;
         data_valid <= 1'b0;
         data_byte  <= '0;
         data_err   <= 1'b0;
      end else begin
         pres_valid <= 1'b0;
         cmd_valid  <= 1'b0;
         rom_valid  <= 1'b0;
         data_valid <= 1'b0;
         if (rp_valid) begin
            st         <= ST_CMD;
            trip       <= TR_TRUE;
            cnt        <= '0;
            pres_valid <= 1'b1;
            pres_flag  <= rp_presence;
         end else if (bit_valid) begin
            case (st)
               ST_CMD: begin
                  if (byte_done) begin
                     cnt       <= '0;
                     cmd_valid <= 1'b1;
                     cmd_byte  <= byte_nxt;
                     cmd_known <= (cls != CL_BAD);
                     case (cls)
                        CL_ADDR:   st <= ST_ADDR;
                        CL_SKIP:   st <= ST_XFER;
                        CL_SEARCH: st <= ST_SEARCH;
                        default:   st <= ST_BAD;
                     endcase
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_ADDR: begin
                  if (addr_done) begin
                     cnt       <= '0;
                     rom_valid <= 1'b1;
                     rom_addr  <= addr_nxt;
                     st        <= ST_XFER;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_SEARCH: begin
                  case (trip)
                     TR_TRUE: trip <= TR_COMP;
                     TR_COMP: trip <= TR_DIR;
                     default: begin
                        trip <= TR_TRUE;
                        if (addr_done) begin
                           cnt       <= '0;
                           rom_valid <= 1'b1;
                           rom_addr  <= addr_nxt;
                           rom_true  <= true_q;
                           rom_comp  <= comp_q;
                           st        <= ST_XFER;
                        end else begin
                           cnt <= cnt + 1'b1;
                        end
                     end
                  endcase
               end
               ST_XFER, ST_BAD: begin
                  if (byte_done) begin
                     cnt        <= '0;
                     data_valid <= 1'b1;
                     data_byte  <= byte_nxt;
                     data_err   <= (st == ST_BAD);
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: st <= ST_CMD;
            endcase
         end
      end
   end
endmodule

// File: rtl/owm_checks.sv
module owm_checks (
   input logic       clk,
   input logic       rst_n,
   input logic       rp_valid,
   input logic       rp_presence,
   input logic       bit_valid,
   input logic       pres_valid,
   input logic       pres_flag,
   input logic       cmd_valid,
   input logic [7:0] cmd_byte,
   input logic       cmd_known,
   input logic       rom_valid,
   input logic       data_valid
);
   AST_PRES_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      rp_valid |=> pres_valid && (pres_flag == $past(rp_presence))); // R1

   AST_RESET_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      rp_valid |=> !(cmd_valid || rom_valid || data_valid)); // R1

   AST_KNOWN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_known == (cmd_byte inside {8'h33, 8'h0F, 8'h55, 8'h69,
                                                    8'hCC, 8'h3C, 8'hF0, 8'hEC}))); // R3

   AST_SINGLE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pres_valid, cmd_valid, rom_valid, data_valid})); // R9

   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rp_valid && !bit_valid) |=> !(pres_valid || cmd_valid || rom_valid || data_valid)); // R9
endmodule

bind owire_netmon owm_checks i_owm_checks (
   .clk(clk), .rst_n(rst_n), .rp_valid(rp_valid), .rp_presence(rp_presence),
   .bit_valid(bit_valid), .pres_valid(pres_valid), .pres_flag(pres_flag),
   .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_known(cmd_known),
   .rom_valid(rom_valid), .data_valid(data_valid)
);

// File: tb/test_owire_netmon.sv
module test_owire_netmon;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rp_valid = 1'b0, rp_presence = 1'b0, bit_valid = 1'b0, bit_value = 1'b0;
   logic pres_valid, pres_flag, cmd_valid, cmd_known, rom_valid, data_valid, data_err;
   logic [7:0] cmd_byte, data_byte;
   logic [AW-1:0] rom_addr, rom_true, rom_comp;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   owire_netmon #(.ADDR_BITS(AW), .KEEP_SEARCH_VECTORS(1'b1)) i_owire_netmon (
      .clk(clk), .rst_n(rst_n), .rp_valid(rp_valid), .rp_presence(rp_presence),
      .bit_valid(bit_valid), .bit_value(bit_value),
      .pres_valid(pres_valid), .pres_flag(pres_flag),
      .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_known(cmd_known),
      .rom_valid(rom_valid), .rom_addr(rom_addr), .rom_true(rom_true), .rom_comp(rom_comp),
      .data_valid(data_valid), .data_byte(data_byte), .data_err(data_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // 0 address, 1 skip, 2 search, 3 unrecognised
   function automatic int exp_class(input logic [7:0] c);
      if (c == 8'h33 || c == 8'h0F || c == 8'h55 || c == 8'h69) return 0;
      if (c == 8'hCC || c == 8'h3C) return 1;
      if (c == 8'hF0 || c == 8'hEC) return 2;
      return 3;
   endfunction

   task automatic drive_bit(input logic b);
      @(negedge clk);
      bit_valid = 1'b1;
      bit_value = b;
      @(negedge clk);
      bit_valid = 1'b0;
   endtask

   task automatic drive_rp(input logic p, input logic with_bit);
      @(negedge clk);
      rp_valid = 1'b1;
      rp_presence = p;
      bit_valid = with_bit;
      bit_value = 1'b1;
      @(negedge clk);
      rp_valid = 1'b0;
      bit_valid = 1'b0;
      check(pres_valid && pres_flag == p, "R1", "presence report",
            {pres_valid, pres_flag}, {1'b1, p});
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) drive_bit(v[i]);
   endtask

   task automatic expect_data(input logic [7:0] v, input logic err, input string req);
      send_byte(v);
      check(data_valid && data_byte == v && data_err == err, req, "data byte",
            {data_valid, data_err, data_byte}, {1'b1, err, v});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!pres_valid && !cmd_valid && !rom_valid && !data_valid, "R9", "reset state",
            {pres_valid, cmd_valid, rom_valid, data_valid}, 0);

      for (int c = 0; c < 256; c++) begin
         logic [7:0] cb;
         logic [AW-1:0] addr, dir, cmp;
         int cl;
         cb = 8'(c);
         cl = exp_class(cb);
         addr = AW'(c * 40503) ^ AW'(16'h5a3c);
         drive_rp(cb[0], 1'b0);
         for (int i = 0; i < 8; i++) begin
            drive_bit(cb[i]);
            if (i == 6)
               check(!cmd_valid, "R2", "no early command", cmd_valid, 0);
         end
         check(cmd_valid && cmd_byte == cb, "R2", "command byte", {cmd_valid, cmd_byte}, {1'b1, cb});
         check(cmd_known == (cl != 3), "R3", "known flag", cmd_known, cl != 3);
         case (cl)
            0: begin
               for (int i = 0; i < AW; i++) drive_bit(addr[i]);
               check(rom_valid && rom_addr == addr, "R4", "plain address",
                     {rom_valid, rom_addr}, {1'b1, addr});
               expect_data(~cb, 1'b0, "R7");
               expect_data(cb ^ 8'h5A, 1'b0, "R7");
            end
            1: begin
               expect_data(cb ^ 8'hA7, 1'b0, "R5");
            end
            2: begin
               for (int i = 0; i < AW; i++) begin
                  dir[i] = addr[i] ^ cb[i % 8];
                  cmp[i] = ~addr[i] ^ (i == 3);
                  drive_bit(addr[i]);
                  drive_bit(cmp[i]);
                  drive_bit(dir[i]);
               end
               check(rom_valid && rom_addr == dir, "R6", "search direction bits",
                     {rom_valid, rom_addr}, {1'b1, dir});
               check(rom_true == addr, "R6", "search true bits", rom_true, addr);
               check(rom_comp == cmp, "R6", "search complement bits", rom_comp, cmp);
               expect_data(cb + 8'd3, 1'b0, "R7");
            end
            default: begin
               expect_data(cb ^ 8'hFF, 1'b1, "R8");
               expect_data(cb, 1'b1, "R8");
            end
         endcase
         @(negedge clk);
         check(!pres_valid && !cmd_valid && !rom_valid && !data_valid, "R9", "quiet after idle",
               {pres_valid, cmd_valid, rom_valid, data_valid}, 0);
      end

      // R1: partial byte dropped, coincident bit dropped
      drive_rp(1'b1, 1'b0);
      for (int i = 0; i < 5; i++) drive_bit(1'b1);
      drive_rp(1'b0, 1'b1);
      send_byte(8'hCC);
      check(cmd_valid && cmd_byte == 8'hCC, "R1", "command after partial byte",
            {cmd_valid, cmd_byte}, {1'b1, 8'hCC});
      expect_data(8'h81, 1'b0, "R5");

      // R1: partial address dropped
      drive_rp(1'b1, 1'b0);
      send_byte(8'h55);
      for (int i = 0; i < 9; i++) drive_bit(1'b1);
      drive_rp(1'b1, 1'b0);
      send_byte(8'h33);
      for (int i = 0; i < AW; i++) drive_bit(AW'(16'h1234) >> i);
      check(rom_valid && rom_addr == AW'(16'h1234), "R1", "address after partial address",
            {rom_valid, rom_addr}, {1'b1, AW'(16'h1234)});

      // R1: partial search triplet dropped
      drive_rp(1'b0, 1'b0);
      send_byte(8'hF0);
      drive_bit(1'b1);
      drive_bit(1'b0);
      drive_rp(1'b0, 1'b0);
      send_byte(8'h3C);
      expect_data(8'h6E, 1'b0, "R1");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule